// File: doc/BRIEF.md
# Cartridge SRAM Address Translator

This block turns a 24-bit CPU bus address (an 8-bit bank on top of a 16-bit offset) into a byte offset for a battery-backed cartridge SRAM. It drives a synchronous SRAM directly. Three mapping modes are available:

- **Banked mode:** the bank number is packed above the low address bits.
- **Windowed mode:** an 8 KB window starting at offset 0x6000 is selected by four bank bits.
- **Work-RAM window:** uses the window offset directly.

A size mask limits the translated offset to the SRAM that is actually fitted. A mask of zero means no SRAM is present, and writes are then dropped in the two masked modes.

The CPU side carries one or two bytes per request. For a two-byte access the high byte belongs to address+1. That address goes through its own translator lane, because with a small mask, or across a window or bank edge, the second byte does not lie next to the first in the SRAM.

Every write that reaches the SRAM sets a sticky modified flag. That flag is what tells the system the battery-backed contents need saving. Mode and mask are configuration inputs and are taken in only while the bus is idle.

Top module: `sram_xlate_top`

## Requirements
- R1: Mode 0 (banked): offset = ((bank << 15) | A[14:0]) & mask, where bank = A[23:16]; address bit 15 has no effect.
- R2: Mode 1 (windowed): offset = ((A[14:0] - 0x6000) + (A[19:16] << 13)) & mask, computed modulo 2^24 and then truncated to AW bits; A[23:20] and A[15] have no effect.
- R3: Mode 2 (work-RAM): offset = (A[14:0] - 0x6000) truncated to AW bits with no mask applied; writes are accepted whatever the mask is.
- R4: In modes 0 and 1, a mask of zero blocks every write: no SRAM write strobe and no change to the modified flag. Reads still go out.
- R5: A request with bus_wide=1 carries bus_wdata[7:0] for address A and bus_wdata[15:8] for A+1 (mod 2^24). A+1 is translated independently on the high lane. The high-lane write strobe is active only on a wide write.
- R6: The modified flag rises the cycle after an accepted write and stays set. A clr_modified pulse clears it one cycle later, but a write in the same cycle as a clear wins.
- R7: cfg_mode and cfg_mask are captured on a clock edge only while bus_req is low, and govern requests from the next cycle. Changes made while bus_req is high are not captured.
- R8: Read data appears on bus_rdata in the cycle after a read request: SRAM byte for A on [7:0], and for A+1 on [15:8] if wide. Each lane is zero in any other cycle, and [15:8] is zero after a one-byte read.
- R9: Mode 3 disables the block. The SRAM enable and write strobes stay low, reads return zero, and the modified flag is unchanged.
- R10: After reset the modified flag is 0, bus_rdata is 0, and the captured configuration is mode 0 with mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Mapping mode: 0 banked, 1 windowed, 2 work-RAM, 3 off |
| cfg_mask | input | AW | SRAM size mask (0 = none fitted) |
| clr_modified | input | 1 | Pulse clearing the modified flag |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = two bytes (A and A+1), 0 = one byte |
| bus_addr | input | 24 | CPU address {bank, offset} |
| bus_wdata | input | 16 | Write data, [7:0] for A, [15:8] for A+1 |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| modified | output | 1 | Sticky flag: SRAM written since last clear |
| sram_en | output | 1 | SRAM access enable for both lanes |
| sram_we_lo | output | 1 | Write strobe, low lane |
| sram_we_hi | output | 1 | Write strobe, high lane |
| sram_addr_lo | output | AW | Translated offset of A |
| sram_addr_hi | output | AW | Translated offset of A+1 |
| sram_wdata_lo | output | 8 | Write byte, low lane |
| sram_wdata_hi | output | 8 | Write byte, high lane |
| sram_rdata_lo | input | 8 | Synchronous SRAM read byte, low lane |
| sram_rdata_hi | input | 8 | Synchronous SRAM read byte, high lane |

## Verification
The SRAM address, enable and write strobes are combinational from the request and the captured configuration. They are checked in the same cycle, one nanosecond after the inputs change on the falling edge.

Read data and the modified flag are due one rising edge later. They are sampled just after that edge, and the lane-zeroing of bus_rdata is sampled again after the following idle edge.

A configuration change is due one edge after an idle cycle. The bench therefore always spends an idle edge on it, and once holds the request high across an edge to show a change is not taken. A small SRAM model in the bench returns a byte computed from the address, so returned data proves which offset was read.

// File: rtl/sram_xlate_pkg.sv
package sram_xlate_pkg;

  localparam int BANK_W   = 8;
  localparam int OFS_W    = 16;
  localparam int BUS_AW   = BANK_W + OFS_W;
  localparam int LOW_W    = 15;
  localparam int IL_SH    = 15;
  localparam int WBANK_W  = 4;
  localparam int WBANK_SH = 13;
  localparam int LANES    = 2;
  localparam logic [BUS_AW-1:0] WIN_BASE = 24'h006000;

  typedef enum logic [1:0] {
    MODE_BANKED   = 2'd0,
    MODE_WINDOWED = 2'd1,
    MODE_WORK     = 2'd2,
    MODE_OFF      = 2'd3
  } xlate_mode_e;

endpackage

// File: rtl/sram_xlate_lane.sv
module sram_xlate_lane
  import sram_xlate_pkg::*;
#(
  parameter int AW = 17
) (
  input  xlate_mode_e       mode,
  input  logic [AW-1:0]     mask,
  input  logic [BUS_AW-1:0] addr,
  output logic [AW-1:0]     ofs
);

  logic [BUS_AW-1:0] low_part;
  logic [BUS_AW-1:0] banked;
  logic [BUS_AW-1:0] work;
  logic [BUS_AW-1:0] windowed;
  logic              lane_unused;

  assign lane_unused = addr[LOW_W];

  always_comb begin
    low_part = {{(BUS_AW-LOW_W){1'b0}}, addr[LOW_W-1:0]};
    banked   = ({{(BUS_AW-BANK_W){1'b0}}, addr[BUS_AW-1:OFS_W]} << IL_SH) | low_part;
    work     = low_part - WIN_BASE;
    windowed = work + ({{(BUS_AW-WBANK_W){1'b0}}, addr[OFS_W+WBANK_W-1:OFS_W]} << WBANK_SH);
    unique case (mode)
      MODE_BANKED:   ofs = banked[AW-1:0] & mask;
      MODE_WINDOWED: ofs = windowed[AW-1:0] & mask;
      MODE_WORK:     ofs = work[AW-1:0];
      default:       ofs = '0;
    endcase
  end

endmodule

// File: rtl/sram_cfg_hold.sv
module sram_cfg_hold
  import sram_xlate_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic [1:0]    mode_in,
  input  logic [AW-1:0] mask_in,
  output xlate_mode_e   mode_q,
  output logic [AW-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BANKED;
      mask_q <= '0;
    end else if (idle) begin
      mode_q <= xlate_mode_e'(mode_in);
      mask_q <= mask_in;
    end
  end

endmodule

// File: rtl/sram_mod_flag.sv
module sram_mod_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

endmodule

// File: rtl/sram_xlate_top.sv
module sram_xlate_top
  import sram_xlate_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_mask,
  input  logic          clr_modified,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic          bus_wide,
  input  logic [23:0]   bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          modified,
  output logic          sram_en,
  output logic          sram_we_lo,
  output logic          sram_we_hi,
  output logic [AW-1:0] sram_addr_lo,
  output logic [AW-1:0] sram_addr_hi,
  output logic [7:0]    sram_wdata_lo,
  output logic [7:0]    sram_wdata_hi,
  input  logic [7:0]    sram_rdata_lo,
  input  logic [7:0]    sram_rdata_hi
);

  xlate_mode_e   cfg_mode_q;
  logic [AW-1:0] cfg_mask_q;
  logic [AW-1:0] lane_ofs [LANES];
  logic          write_ok;
  logic          rd_lo_q;
  logic          rd_hi_q;

  sram_cfg_hold #(.AW(AW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .idle    (!bus_req),
    .mode_in (cfg_mode),
    .mask_in (cfg_mask),
    .mode_q  (cfg_mode_q),
    .mask_q  (cfg_mask_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_AW-1:0] lane_addr;
    assign lane_addr = bus_addr + BUS_AW'(g);
    sram_xlate_lane #(.AW(AW)) u_lane (
      .mode (cfg_mode_q),
      .mask (cfg_mask_q),
      .addr (lane_addr),
      .ofs  (lane_ofs[g])
    );
  end

  always_comb begin
    unique case (cfg_mode_q)
      MODE_BANKED, MODE_WINDOWED: write_ok = (cfg_mask_q != '0);
      MODE_WORK:                  write_ok = 1'b1;
      default:                    write_ok = 1'b0;
    endcase
  end

  assign sram_en       = bus_req && (cfg_mode_q != MODE_OFF);
  assign sram_we_lo    = bus_req && bus_we && write_ok;
  assign sram_we_hi    = sram_we_lo && bus_wide;
  assign sram_addr_lo  = lane_ofs[0];
  assign sram_addr_hi  = lane_ofs[1];
  assign sram_wdata_lo = bus_wdata[7:0];
  assign sram_wdata_hi = bus_wdata[15:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_lo_q <= 1'b0;
      rd_hi_q <= 1'b0;
    end else begin
      rd_lo_q <= sram_en && !bus_we;
      rd_hi_q <= sram_en && !bus_we && bus_wide;
    end
  end

  assign bus_rdata = {rd_hi_q ? sram_rdata_hi : 8'h00,
                      rd_lo_q ? sram_rdata_lo : 8'h00};

  sram_mod_flag u_mod (
    .clk    (clk),
    .rst    (rst),
    .set_i  (sram_we_lo),
    .clr_i  (clr_modified),
    .flag_q (modified)
  );

endmodule

// File: rtl/sram_xlate_chk.sv
module sram_xlate_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_wide,
  input logic [15:0]   bus_rdata,
  input logic          sram_en,
  input logic          sram_we_lo,
  input logic          sram_we_hi,
  input logic [AW-1:0] sram_addr_lo,
  input logic [1:0]    cfg_mode_q,
  input logic [AW-1:0] cfg_mask_q,
  input logic          modified,
  input logic          clr_modified
);

  AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (sram_en && (cfg_mode_q == 2'd0 || cfg_mode_q == 2'd1)) |-> ((sram_addr_lo & ~cfg_mask_q) == '0)); // R1
  AST_NO_WR_MASK0: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode_q == 2'd0 || cfg_mode_q == 2'd1) && cfg_mask_q == '0) |-> !sram_we_lo); // R4
  AST_HI_WE_WIDE: assert property (@(posedge clk) disable iff (rst)
    sram_we_hi |-> (sram_we_lo && bus_wide)); // R5
  AST_MOD_SET: assert property (@(posedge clk) disable iff (rst)
    sram_we_lo |=> modified); // R6
  AST_MOD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (modified && !clr_modified) |=> modified); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> ($stable(cfg_mode_q) && $stable(cfg_mask_q))); // R7
  AST_RD_LO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(sram_en && !bus_we) |=> (bus_rdata[7:0] == 8'h00)); // R8
  AST_RD_HI_IDLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_wide) |=> (bus_rdata[15:8] == 8'h00)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode_q == 2'd3) |-> (!sram_en && !sram_we_lo)); // R9

endmodule

bind sram_xlate_top sram_xlate_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_wide     (bus_wide),
  .bus_rdata    (bus_rdata),
  .sram_en      (sram_en),
  .sram_we_lo   (sram_we_lo),
  .sram_we_hi   (sram_we_hi),
  .sram_addr_lo (sram_addr_lo),
  .cfg_mode_q   (cfg_mode_q),
  .cfg_mask_q   (cfg_mask_q),
  .modified     (modified),
  .clr_modified (clr_modified)
);

// File: tb/test_sram_xlate_top.sv
`timescale 1ns/1ps
module test_sram_xlate_top;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_mode = 2'd0;
  logic [AW-1:0] cfg_mask = '0;
  logic          clr_modified = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic          bus_wide = 1'b0;
  logic [23:0]   bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          modified;
  logic          sram_en, sram_we_lo, sram_we_hi;
  logic [AW-1:0] sram_addr_lo, sram_addr_hi;
  logic [7:0]    sram_wdata_lo, sram_wdata_hi;
  logic [7:0]    sram_rdata_lo = '0;
  logic [7:0]    sram_rdata_hi = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_xlate_top #(.AW(AW)) i_sram_xlate_top (.*);

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
  endfunction

  // synchronous SRAM model: data one edge after enable
  always_ff @(posedge clk) begin
    if (sram_en) begin
      sram_rdata_lo <= pat(sram_addr_lo);
      sram_rdata_hi <= pat(sram_addr_hi);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic wide, input logic [23:0] a,
                        input logic [15:0] wd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_wide = wide; bus_addr = a; bus_wdata = wd;
    #1;
  endtask

  task automatic edge_wait;
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wide = 1'b0; clr_modified = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [AW-1:0] mk);
    go_idle();
    cfg_mode = m; cfg_mask = mk;
    edge_wait();
  endtask

  task automatic clear_flag;
    go_idle();
    clr_modified = 1'b1;
    edge_wait();
    clr_modified = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 modified after reset", modified, 0);
    chk("R10 rdata after reset", bus_rdata, 0);
    access(1'b1, 1'b0, 24'h00_0010, 16'h0011);
    chk("R10/R4 reset mask zero blocks write", sram_we_lo, 0);
    chk("R10 reset mode banked addr", sram_addr_lo, 17'h0);
    edge_wait();
    chk("R4 modified untouched", modified, 0);
  endtask

  task automatic t_banked;
    set_cfg(2'd0, 17'h1FFFF);
    access(1'b0, 1'b0, 24'h03_1234, 16'h0);
    chk("R1 banked addr", sram_addr_lo, 17'h19234);
    chk("R1 read no write strobe", sram_we_lo, 0);
    edge_wait();
    chk("R8 byte read data", bus_rdata, {8'h00, pat(17'h19234)});
    go_idle();
    edge_wait();
    chk("R8 rdata zero after idle", bus_rdata, 0);
    access(1'b0, 1'b0, 24'h03_9234, 16'h0);
    chk("R1 bit15 ignored", sram_addr_lo, 17'h19234);
    set_cfg(2'd0, 17'h007FF);
    access(1'b1, 1'b0, 24'h03_1234, 16'h005A);
    chk("R1 masked addr", sram_addr_lo, 17'h00234);
    chk("R6 write strobe lo", sram_we_lo, 1);
    chk("R5 no hi strobe on byte", sram_we_hi, 0);
    chk("R5 write byte lo", sram_wdata_lo, 8'h5A);
    edge_wait();
    chk("R6 modified set", modified, 1);
  endtask

  task automatic t_flag;
    go_idle();
    edge_wait();
    chk("R6 modified sticky", modified, 1);
    clear_flag();
    chk("R6 clear pulse", modified, 0);
    access(1'b1, 1'b0, 24'h00_0001, 16'h0001);
    clr_modified = 1'b1;
    edge_wait();
    chk("R6 write wins over clear", modified, 1);
    clear_flag();
    chk("R6 cleared again", modified, 0);
  endtask

  task automatic t_windowed;
    set_cfg(2'd1, 17'h1FFFF);
    access(1'b0, 1'b0, 24'h05_7001, 16'h0);
    chk("R2 windowed addr", sram_addr_lo, 17'h0B001);
    access(1'b0, 1'b0, 24'h25_F001, 16'h0);
    chk("R2 upper bank bits and bit15 ignored", sram_addr_lo, 17'h0B001);
    access(1'b0, 1'b0, 24'h00_5000, 16'h0);
    chk("R2 below window base wraps", sram_addr_lo, 17'h1F000);
    edge_wait();
    chk("R8 windowed read data", bus_rdata, {8'h00, pat(17'h1F000)});
  endtask

  task automatic t_work;
    set_cfg(2'd2, 17'h0);
    access(1'b1, 1'b0, 24'h40_6123, 16'h0077);
    chk("R3 work addr", sram_addr_lo, 17'h00123);
    chk("R3 write with zero mask", sram_we_lo, 1);
    edge_wait();
    chk("R3 modified set", modified, 1);
    clear_flag();
  endtask

  task automatic t_mask_zero;
    set_cfg(2'd1, 17'h0);
    access(1'b1, 1'b1, 24'h01_6000, 16'h1234);
    chk("R4 window mask zero lo strobe", sram_we_lo, 0);
    chk("R4 window mask zero hi strobe", sram_we_hi, 0);
    chk("R4 read path still enabled", sram_en, 1);
    edge_wait();
    chk("R4 modified unchanged", modified, 0);
  endtask

  task automatic t_wide;
    set_cfg(2'd0, 17'h007FF);
    access(1'b1, 1'b1, 24'h02_7FFF, 16'hBEEF);
    chk("R5 lo addr", sram_addr_lo, 17'h007FF);
    chk("R5 hi addr not adjacent", sram_addr_hi, 17'h00000);
    chk("R5 hi strobe", sram_we_hi, 1);
    chk("R5 hi byte", sram_wdata_hi, 8'hBE);
    clear_flag();
    set_cfg(2'd0, 17'h1FFFF);
    access(1'b0, 1'b1, 24'h01_FFFF, 16'h0);
    chk("R5 bank carry lo", sram_addr_lo, 17'h0FFFF);
    chk("R5 bank carry hi", sram_addr_hi, 17'h10000);
    edge_wait();
    chk("R8 wide read data", bus_rdata, {pat(17'h10000), pat(17'h0FFFF)});
    access(1'b0, 1'b1, 24'hFF_FFFF, 16'h0);
    chk("R5 top wrap lo", sram_addr_lo, 17'h1FFFF);
    chk("R5 top wrap hi", sram_addr_hi, 17'h00000);
    set_cfg(2'd1, 17'h1FFFF);
    access(1'b0, 1'b1, 24'h00_7FFF, 16'h0);
    chk("R5 window edge lo", sram_addr_lo, 17'h01FFF);
    chk("R5 window edge hi", sram_addr_hi, 17'h1A000);
  endtask

  task automatic t_cfg_busy;
    set_cfg(2'd0, 17'h1FFFF);
    access(1'b0, 1'b0, 24'h05_7001, 16'h0);
    cfg_mode = 2'd1;
    chk("R7 still banked", sram_addr_lo, 17'h0F001);
    edge_wait();
    access(1'b0, 1'b0, 24'h05_7001, 16'h0);
    chk("R7 busy change not taken", sram_addr_lo, 17'h0F001);
    edge_wait();
    go_idle();
    edge_wait();
    access(1'b0, 1'b0, 24'h05_7001, 16'h0);
    chk("R7 taken after idle", sram_addr_lo, 17'h0B001);
  endtask

  task automatic t_off;
    set_cfg(2'd3, 17'h1FFFF);
    access(1'b1, 1'b0, 24'h00_0000, 16'h00FF);
    chk("R9 enable low", sram_en, 0);
    chk("R9 no write", sram_we_lo, 0);
    edge_wait();
    chk("R9 modified unchanged", modified, 0);
    access(1'b0, 1'b1, 24'h00_0000, 16'h0);
    edge_wait();
    chk("R9 read returns zero", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_banked();
    t_flag();
    t_windowed();
    t_work();
    t_mask_zero();
    t_wide();
    t_cfg_busy();
    t_off();
    go_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule